// File: doc/BRIEF.md
# USB Endpoint Handshake Status Controller

This block keeps the handshake state of a small USB device function with three endpoints. Each endpoint has a receive slot and a transmit slot, and each slot holds a two-bit status: disabled, STALL, NAK or VALID. The packet engine presents the endpoint, direction and address of the token it is handling. The block answers at once with the handshake to give: no answer, STALL, NAK, or accept/send. A transmit slot also carries a byte count that tells the packet engine how many bytes to send.

When the packet engine reports a completed transaction, the hardware moves the used slot to NAK. For a SETUP it moves both slots of that endpoint to NAK. It also raises a correct-transfer flag and captures the token PID and the endpoint number. While the flag is pending, every VALID slot answers NAK, and the captured values stay frozen until software clears the flag. A USB bus reset zeroes the device address and disables every slot. Software then brings endpoint 0 back by writing VALID to its receive status.

Each slot is a four-state machine: EP_DISABLED, EP_STALL, EP_NAK and EP_VALID. Software writes move a slot to any state. The `force` transition takes any state to EP_NAK on a completion. The `bus reset` transition takes any state to EP_DISABLED. The `locked` hold keeps EP_VALID in place against a write while a transaction on that slot is in progress. The flag is a two-state machine, FLAG_IDLE and FLAG_PENDING. The `raise` transition goes IDLE to PENDING on a completion and captures the token. The `clear` transition goes PENDING to IDLE on a clearing write. The `re-arm` transition stays in PENDING and captures the new token when a clear and a completion arrive in the same cycle.

Top module: `usb_ep_handshake_ctrl`

## Requirements
- R1: Status encoding is 00 disabled, 01 STALL, 10 NAK, 11 VALID. With the flag clear and the token address matching, the answer `hs_answer` is 00 (none) for disabled, 01 for STALL, 10 for NAK and 11 (accept/send) for VALID. An endpoint number at or above the endpoint count gets 00.
- R2: A non-SETUP completion sets the status of the used direction (`done_dir` 0 = receive, 1 = transmit) of `done_ep` to NAK. The other direction is left unchanged.
- R3: A SETUP completion sets both the receive and the transmit status of that endpoint to NAK.
- R4: A completion sets `ctr_flag` on the next clock edge. While the flag is set, a VALID slot answers 10 (NAK).
- R5: When the flag is clear, a completion captures `done_pid` into `last_pid` and `done_ep` into `last_ep`. While the flag is set, both hold their value through further completions.
- R6: A write of 0 in data bit 0 to register 1 clears the flag. When a completion arrives in the same cycle, the flag stays set and the captured values take that completion's PID and endpoint.
- R7: A bus reset clears `dev_addr` to 0 and sets every slot to disabled, so every token gets answer 00.
- R8: After a bus reset, endpoint 0 answers only once software writes 11 to its receive register (address 5 + 0, data bits 1:0). Its transmit slot stays disabled.
- R9: A write to a transmit register (address 2 + endpoint) sets the status from data bits 1:0 and the byte count from data bits 7:4. `tx_bytes` shows the count of the token's endpoint.
- R10: A CPU status write to a slot is ignored while that slot is VALID and `tok_active` is high with `tok_ep`/`tok_dir` on that slot. Once `tok_active` is low, the write takes effect.
- R11: A write to register 0 loads data bits 6:0 into `dev_addr`. A token whose `tok_addr` differs from `dev_addr` gets answer 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | USB bus reset event, one cycle |
| tok_ep | input | EP_W | Endpoint of the current token |
| tok_dir | input | 1 | Token direction, 0 receive, 1 transmit |
| tok_addr | input | ADDR_W | Address field of the current token |
| tok_active | input | 1 | A transaction on tok_ep/tok_dir is in progress |
| done_valid | input | 1 | Transaction completed correctly, one cycle |
| done_ep | input | EP_W | Endpoint of the completed transaction |
| done_dir | input | 1 | Direction of the completed transaction |
| done_setup | input | 1 | Completed transaction was a SETUP |
| done_pid | input | PID_W | Token PID of the completed transaction |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | REG_AW | CPU register select |
| cpu_wdata | input | DATA_W | CPU write data |
| hs_answer | output | 2 | Handshake to give: 00 none, 01 STALL, 10 NAK, 11 accept/send |
| tx_bytes | output | CNT_W | Transmit byte count of tok_ep |
| ctr_flag | output | 1 | Correct-transfer flag |
| last_pid | output | PID_W | Captured token PID |
| last_ep | output | EP_W | Captured endpoint number |
| dev_addr | output | ADDR_W | Device address |

## Verification
The handshake answer is tried with every status value on different endpoints and directions. This tells the decode apart from the slot selection. The answer is also tried with a matching and a mismatching token address, and before and after a completion. That separates the pending-flag override from the stored status. Completions are applied as a plain receive, a plain transmit, a SETUP, a second event while the flag is pending, and an event in the same cycle as the clear. Together these separate the one-direction and both-direction forcing, the freeze of the captured values, and the rule that a new event wins. A write during an active transaction on a VALID slot is followed by the same write with no transaction. A bus reset is followed by the re-enabling of endpoint 0.

// File: rtl/usbhs_pkg.sv
package usbhs_pkg;

    typedef enum logic [1:0] {
        EP_DISABLED = 2'b00,
        EP_STALL    = 2'b01,
        EP_NAK      = 2'b10,
        EP_VALID    = 2'b11
    } ep_stat_e;

    typedef enum logic [1:0] {
        HS_NONE   = 2'b00,
        HS_STALL  = 2'b01,
        HS_NAK    = 2'b10,
        HS_ACCEPT = 2'b11
    } hs_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/usbhs_ep_slot.sv
module usbhs_ep_slot
    import usbhs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       force_nak,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    input  logic       busy,
    output ep_stat_e   stat,
    output logic       wr_taken
);

    ep_stat_e cur_q, nxt;
    logic     wr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= EP_DISABLED;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt   = cur_q;
        wr_ok = 1'b0;
        unique case (cur_q)
            EP_DISABLED, EP_STALL, EP_NAK: wr_ok = wr_en;
            EP_VALID:                      wr_ok = wr_en && !busy;  // locked hold
        endcase
        if (wr_ok)     nxt = ep_stat_e'(wr_val);
        if (force_nak) nxt = EP_NAK;
        if (bus_rst)   nxt = EP_DISABLED;
    end

    always_comb begin
        stat     = cur_q;
        wr_taken = wr_ok && !force_nak && !bus_rst;
    end

    a_r7_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (stat == EP_DISABLED));

    a_r2_force_to_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (force_nak && !bus_rst) |=> (stat == EP_NAK));

    a_r10_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == EP_VALID && busy && !force_nak && !bus_rst) |=> (stat == EP_VALID));

endmodule

// File: rtl/usbhs_xfer_latch.sv
module usbhs_xfer_latch
    import usbhs_pkg::*;
#(
    parameter int EP_W  = 2,
    parameter int PID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [EP_W-1:0]  done_ep,
    input  logic [PID_W-1:0] done_pid,
    input  logic             clr,
    output logic             flag,
    output logic [EP_W-1:0]  last_ep,
    output logic [PID_W-1:0] last_pid
);

    flag_state_e      st_q, st_nxt;
    logic             capture;
    logic [EP_W-1:0]  ep_q;
    logic [PID_W-1:0] pid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLAG_IDLE;
            ep_q  <= '0;
            pid_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (capture) begin
                ep_q  <= done_ep;
                pid_q <= done_pid;
            end
        end
    end

    always_comb begin
        st_nxt  = st_q;
        capture = 1'b0;
        unique case (st_q)
            FLAG_IDLE: if (done) begin            // raise
                st_nxt  = FLAG_PENDING;
                capture = 1'b1;
            end
            FLAG_PENDING: if (clr && done) begin  // re-arm
                capture = 1'b1;
            end else if (clr) begin               // clear
                st_nxt = FLAG_IDLE;
            end
        endcase
    end

    always_comb begin
        flag     = (st_q == FLAG_PENDING);
        last_ep  = ep_q;
        last_pid = pid_q;
    end

    a_r4_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !done) |=> !flag);

    a_r5_info_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> ($stable(last_pid) && $stable(last_ep)));

    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && done) |=> (flag && last_pid == $past(done_pid)));

endmodule

// File: rtl/usbhs_resp.sv
module usbhs_resp
    import usbhs_pkg::*;
(
    input  ep_stat_e stat,
    input  logic     pending,
    input  logic     hit,
    output hs_e      hs
);

    always_comb begin
        hs = HS_NONE;
        if (hit) begin
            unique case (stat)
                EP_DISABLED: hs = HS_NONE;
                EP_STALL:    hs = HS_STALL;
                EP_NAK:      hs = HS_NAK;
                EP_VALID:    hs = pending ? HS_NAK : HS_ACCEPT;
            endcase
        end
    end

endmodule

// File: rtl/usb_ep_handshake_ctrl.sv
module usb_ep_handshake_ctrl
    import usbhs_pkg::*;
#(
    parameter int NUM_EP = 3,
    parameter int EP_W   = $clog2(NUM_EP),
    parameter int ADDR_W = 7,
    parameter int PID_W  = 4,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8,
    parameter int REG_AW = $clog2(2 + 2 * NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_dir,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic              tok_active,
    input  logic              done_valid,
    input  logic [EP_W-1:0]   done_ep,
    input  logic              done_dir,
    input  logic              done_setup,
    input  logic [PID_W-1:0]  done_pid,
    input  logic              cpu_we,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [1:0]        hs_answer,
    output logic [CNT_W-1:0]  tx_bytes,
    output logic              ctr_flag,
    output logic [PID_W-1:0]  last_pid,
    output logic [EP_W-1:0]   last_ep,
    output logic [ADDR_W-1:0] dev_addr
);

    localparam int CNT_LSB = DATA_W - CNT_W;
    localparam logic [REG_AW-1:0] A_DEVADDR = REG_AW'(0);
    localparam logic [REG_AW-1:0] A_FLAG    = REG_AW'(1);
    localparam int TX_BASE = 2;
    localparam int RX_BASE = 2 + NUM_EP;
    localparam logic [EP_W:0] NUM_EP_C = (EP_W + 1)'(NUM_EP);

    ep_stat_e          stat_arr  [NUM_EP][2];
    logic              taken_arr [NUM_EP][2];
    logic [CNT_W-1:0]  cnt_q     [NUM_EP];
    logic [ADDR_W-1:0] addr_q;
    logic              flag_clr;
    logic              in_range;
    logic              hit;
    ep_stat_e          sel_stat;
    hs_e               hs;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        for (genvar d = 0; d < 2; d++) begin : g_dir
            localparam logic [REG_AW-1:0] MY_ADDR =
                REG_AW'((d == 1) ? (TX_BASE + e) : (RX_BASE + e));
            usbhs_ep_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .bus_rst   (bus_reset),
                .force_nak (done_valid && done_ep == EP_W'(e) &&
                            (done_setup || done_dir == 1'(d))),
                .wr_en     (cpu_we && cpu_addr == MY_ADDR),
                .wr_val    (cpu_wdata[1:0]),
                .busy      (tok_active && tok_ep == EP_W'(e) && tok_dir == 1'(d)),
                .stat      (stat_arr[e][d]),
                .wr_taken  (taken_arr[e][d])
            );
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q[e] <= '0;
            else if (taken_arr[e][1]) cnt_q[e] <= cpu_wdata[CNT_LSB +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              addr_q <= '0;
        else if (bus_reset)                      addr_q <= '0;
        else if (cpu_we && cpu_addr == A_DEVADDR) addr_q <= cpu_wdata[ADDR_W-1:0];
    end

    assign flag_clr = cpu_we && cpu_addr == A_FLAG && !cpu_wdata[0];

    usbhs_xfer_latch #(.EP_W(EP_W), .PID_W(PID_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done_valid),
        .done_ep  (done_ep),
        .done_pid (done_pid),
        .clr      (flag_clr),
        .flag     (ctr_flag),
        .last_ep  (last_ep),
        .last_pid (last_pid)
    );

    always_comb begin
        in_range = ({1'b0, tok_ep} < NUM_EP_C);
        hit      = in_range && (tok_addr == addr_q);
        sel_stat = in_range ? stat_arr[tok_ep][tok_dir] : EP_DISABLED;
        tx_bytes = in_range ? cnt_q[tok_ep] : '0;
    end

    usbhs_resp u_resp (
        .stat    (sel_stat),
        .pending (ctr_flag),
        .hit     (hit),
        .hs      (hs)
    );

    assign hs_answer = hs;
    assign dev_addr  = addr_q;

    a_r7_addr_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (dev_addr == '0));

    a_r4_pending_naks: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_flag && hit && sel_stat == EP_VALID) |-> (hs_answer == HS_NAK));

    a_r11_addr_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_addr != dev_addr) |-> (hs_answer == HS_NONE));

endmodule

// File: tb/usb_ep_handshake_ctrl_tb.sv
module usb_ep_handshake_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic [1:0] tok_ep = '0;
    logic       tok_dir = 1'b0;
    logic [6:0] tok_addr = '0;
    logic       tok_active = 1'b0;
    logic       done_valid = 1'b0;
    logic [1:0] done_ep = '0;
    logic       done_dir = 1'b0;
    logic       done_setup = 1'b0;
    logic [3:0] done_pid = '0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [1:0] hs_answer;
    logic [3:0] tx_bytes;
    logic       ctr_flag;
    logic [3:0] last_pid;
    logic [1:0] last_ep;
    logic [6:0] dev_addr;

    always #5 clk = ~clk;

    usb_ep_handshake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .tok_ep(tok_ep), .tok_dir(tok_dir), .tok_addr(tok_addr), .tok_active(tok_active),
        .done_valid(done_valid), .done_ep(done_ep), .done_dir(done_dir),
        .done_setup(done_setup), .done_pid(done_pid),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .hs_answer(hs_answer), .tx_bytes(tx_bytes), .ctr_flag(ctr_flag),
        .last_pid(last_pid), .last_ep(last_ep), .dev_addr(dev_addr)
    );

    typedef struct {
        int    sel;
        int    exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    localparam int S_HS = 0, S_FLAG = 1, S_PID = 2, S_EP = 3, S_ADDR = 4, S_CNT = 5;

    function automatic int pick(int sel);
        case (sel)
            S_HS:    return int'(hs_answer);
            S_FLAG:  return int'(ctr_flag);
            S_PID:   return int'(last_pid);
            S_EP:    return int'(last_ep);
            S_ADDR:  return int'(dev_addr);
            default: return int'(tx_bytes);
        endcase
    endfunction

    // monitor: compares one expected item per clock, away from the edge
    initial forever begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            int    act;
            it  = sb_q.pop_front();
            act = pick(it.sel);
            n_cmp++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
            end
        end
    end

    // driver: present a token and push the expected result
    task automatic expect_out(input int sel, input int ep, input int dir,
                              input int addr, input int exp, input string tag);
        item_t it;
        @(negedge clk);
        tok_ep     = 2'(ep);
        tok_dir    = 1'(dir);
        tok_addr   = 7'(addr);
        tok_active = 1'b0;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic cpu_wr(input int a, input int d);
        @(negedge clk);
        cpu_we    = 1'b1;
        cpu_addr  = 3'(a);
        cpu_wdata = 8'(d);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic complete(input int ep, input int dir, input bit setup, input int pid);
        @(negedge clk);
        done_valid = 1'b1;
        done_ep    = 2'(ep);
        done_dir   = 1'(dir);
        done_setup = setup;
        done_pid   = 4'(pid);
        @(negedge clk);
        done_valid = 1'b0;
        done_setup = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=end");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        expect_out(S_HS,   0, 0, 0, 0, "R7 reset: ep0 rx disabled");
        expect_out(S_FLAG, 0, 0, 0, 0, "R4 reset: flag clear");
        expect_out(S_ADDR, 0, 0, 0, 0, "R7 reset: address zero");

        cpu_wr(5, 3);
        expect_out(S_HS, 0, 0, 0, 3, "R8 ep0 rx valid accepts");

        cpu_wr(0, 8'h2A);
        expect_out(S_ADDR, 0, 0, 0, 8'h2A, "R11 address written");
        expect_out(S_HS, 0, 0, 0, 0, "R11 mismatched address ignored");
        expect_out(S_HS, 0, 0, 8'h2A, 3, "R1 valid accepts at own address");

        cpu_wr(3, 8'h51);
        expect_out(S_HS,  1, 1, 8'h2A, 1, "R1 stall answered");
        expect_out(S_CNT, 1, 1, 8'h2A, 5, "R9 byte count 5");
        cpu_wr(3, 8'h63);
        expect_out(S_HS,  1, 1, 8'h2A, 3, "R9 tx valid sends");
        expect_out(S_CNT, 1, 1, 8'h2A, 6, "R9 byte count 6");
        cpu_wr(6, 2);
        expect_out(S_HS, 1, 0, 8'h2A, 2, "R1 nak answered");
        cpu_wr(6, 3);
        expect_out(S_HS, 2, 0, 8'h2A, 0, "R1 disabled ep2 silent");
        expect_out(S_HS, 3, 0, 8'h2A, 0, "R1 out-of-range endpoint silent");

        complete(1, 1, 1'b0, 9);
        expect_out(S_FLAG, 0, 0, 8'h2A, 1, "R4 flag raised");
        expect_out(S_PID,  0, 0, 8'h2A, 9, "R5 pid captured");
        expect_out(S_EP,   0, 0, 8'h2A, 1, "R5 ep captured");
        expect_out(S_HS,   0, 0, 8'h2A, 2, "R4 valid ep0 naked while pending");

        complete(0, 0, 1'b0, 1);
        expect_out(S_PID, 0, 0, 8'h2A, 9, "R5 pid frozen");
        expect_out(S_EP,  0, 0, 8'h2A, 1, "R5 ep frozen");

        cpu_wr(1, 0);
        expect_out(S_FLAG, 0, 0, 8'h2A, 0, "R6 flag cleared");
        expect_out(S_HS, 1, 0, 8'h2A, 3, "R2 other direction untouched");
        expect_out(S_HS, 1, 1, 8'h2A, 2, "R2 used direction naked");
        expect_out(S_HS, 0, 0, 8'h2A, 2, "R2 second completion naked ep0 rx");

        cpu_wr(2, 3);
        cpu_wr(5, 3);
        complete(0, 0, 1'b1, 8'hD);
        expect_out(S_PID, 0, 0, 8'h2A, 8'hD, "R5 setup pid captured");
        cpu_wr(1, 0);
        expect_out(S_HS, 0, 1, 8'h2A, 2, "R3 setup naks tx");
        expect_out(S_HS, 0, 0, 8'h2A, 2, "R3 setup naks rx");

        complete(1, 0, 1'b0, 1);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 3'd1; cpu_wdata = 8'h00;
        done_valid = 1'b1; done_ep = 2'd0; done_dir = 1'b1; done_pid = 4'd9;
        @(negedge clk);
        cpu_we = 1'b0; done_valid = 1'b0;
        expect_out(S_FLAG, 0, 0, 8'h2A, 1, "R6 same-cycle event keeps flag");
        expect_out(S_PID,  0, 0, 8'h2A, 9, "R6 same-cycle event pid");
        expect_out(S_EP,   0, 0, 8'h2A, 0, "R6 same-cycle event ep");
        cpu_wr(1, 0);
        expect_out(S_FLAG, 0, 0, 8'h2A, 0, "R6 cleared again");

        cpu_wr(4, 3);
        @(negedge clk);
        tok_active = 1'b1; tok_ep = 2'd2; tok_dir = 1'b1;
        cpu_we = 1'b1; cpu_addr = 3'd4; cpu_wdata = 8'h01;
        @(negedge clk);
        cpu_we = 1'b0; tok_active = 1'b0;
        expect_out(S_HS, 2, 1, 8'h2A, 3, "R10 locked write ignored");
        cpu_wr(4, 1);
        expect_out(S_HS, 2, 1, 8'h2A, 1, "R10 idle write taken");

        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        expect_out(S_ADDR, 0, 0, 0, 0, "R7 bus reset zeroes address");
        expect_out(S_HS, 1, 0, 0, 0, "R7 bus reset disables ep1");
        expect_out(S_HS, 0, 0, 0, 0, "R8 ep0 silent after bus reset");
        cpu_wr(5, 3);
        expect_out(S_HS, 0, 0, 0, 3, "R8 ep0 rx re-enabled");
        expect_out(S_HS, 0, 1, 0, 0, "R8 ep0 tx still disabled");

        summary();
    end

endmodule